// File: doc/BRIEF.md
# 2B+D Line Frame and Superframe Assembler

This block turns per-group channel data for a 2B+D subscriber line into the transmit quaternary symbol (quat) stream. Each frame holds 120 quats and lasts 1.5 ms. A frame opens with a nine-quat framing word. Twelve data groups follow, each holding eight B1 bits, eight B2 bits and two D bits. Three maintenance quats close the frame. Eight frames make a superframe. Frame 0 of every superframe carries the sign-inverted framing word, which marks the superframe boundary. The result feeds a downstream scrambler and symbol mapper. A flag marks which quats belong to the framing word, so that the mapper can keep them out of scrambling.

The block moves one quat forward on each cycle in which `quat_en` is high. A state machine with three states gives the position inside the frame. `SYNC` covers quats 0 to 8. `SYNC_TO_DATA` fires after quat 8 and leads to `DATA`, which covers quats 9 to 116. `DATA_TO_MAINT` fires after quat 116 and leads to `MAINT`, which covers quats 117 to 119. `MAINT_TO_SYNC` fires after quat 119, returns to `SYNC` and advances the frame counter, which wraps from 7 to 0. A group's 18 bits are taken from the inputs at the group's first quat, and `grp_take` shows that moment to the upstream logic. The maintenance bits are taken the same way at quat 117, shown by `mnt_take`. The remaining quats come out of a shift register, so the inputs may change freely in between.

Top module: `dsl_frame_asm`

## Requirements
- R1: While reset is held, and until the first `quat_en`, all of `quat_vld`, `quat_out`, `sync_flag`, `quat_idx` and `frame_idx` are zero. `grp_take` and `mnt_take` stay low while `quat_en` is low.
- R2: Each cycle with `quat_en` high emits exactly one quat, and the outputs are registered. In the next cycle `quat_vld` is high and `quat_idx` gives the quat's position. Positions run 0,1,…,119 and then wrap to 0. The first quat after reset is position 0.
- R3: `frame_idx` gives the frame of the emitted quat. It advances by one after position 119 and wraps from 7 to 0. The first frame after reset is frame 0.
- R4: In frames 1 to 7, positions 0 to 8 carry +3,+3,-3,-3,-3,+3,-3,+3,+3 with `sync_flag` high. The quat code is {sign, magnitude}: +3=2'b10, +1=2'b11, -1=2'b01, -3=2'b00.
- R5: In frame 0, positions 0 to 8 carry the inverted word -3,-3,+3,+3,+3,-3,+3,-3,-3 with `sync_flag` high.
- R6: Positions 9 to 116 hold twelve groups of nine quats. Each group sends `b1_in[7:0]`, then `b2_in[7:0]`, then `d_in[7:6]`, as bit pairs with the earlier bit in `quat_out[1]`. Bit 7 of each field is sent first.
- R7: `grp_take` is high, combinationally, exactly in the `quat_en` cycle that emits a group's first quat (positions 9+9g). Only then are `b1_in`, `b2_in` and `d_in` sampled. At any other time their values have no effect.
- R8: `d_in[5:0]` never affects the output.
- R9: Positions 117 to 119 carry `m_in[5:0]` as pairs, MSB first. The value is sampled only in the `quat_en` cycle that emits position 117, which `mnt_take` marks.
- R10: `sync_flag` is low for every quat at positions 9 to 119.
- R11: In a cycle with `quat_en` low, the next cycle shows `quat_vld` low, and `quat_out`, `sync_flag`, `quat_idx` and `frame_idx` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quat_en | input | 1 | Advance one quat this cycle |
| b1_in | input | 8 | B1 byte for the next group |
| b2_in | input | 8 | B2 byte for the next group |
| d_in | input | 8 | System-side D byte; only bits 7:6 are sent |
| m_in | input | 6 | Maintenance bits for the frame |
| grp_take | output | 1 | Group inputs sampled this cycle |
| mnt_take | output | 1 | Maintenance inputs sampled this cycle |
| quat_vld | output | 1 | A new quat is on the outputs |
| quat_out | output | 2 | Quat code {sign, magnitude} |
| sync_flag | output | 1 | Quat belongs to the framing word |
| quat_idx | output | 7 | Position of the quat in its frame, 0..119 |
| frame_idx | output | 3 | Frame in the superframe, 0..7 |

## Verification
The bench runs through more than nine full frames, so every frame index appears and the superframe wraps. This separates the inverted word in frame 0 from the normal word in frames 1 to 7. Group and maintenance data are random, and the inputs hold unrelated random values on every cycle except the sampling cycle. A design that samples at the wrong quat, or that reads live inputs in the middle of a group, therefore sends the wrong bits. The unused D bits are also random, which exposes any leak from them into the stream. Every seventh cycle leaves `quat_en` low, which shows the hold behaviour and proves that position counting follows enables and not clock cycles.

// File: rtl/dsl_fa_pkg.sv
package dsl_fa_pkg;

    // Frame position phases
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_DATA  = 2'd1,
        PH_MAINT = 2'd2
    } phase_t;

    localparam int SYNC_QUATS = 9;

    // Sign bits of the framing word, first quat at the MSB (1 = +3, 0 = -3)
    localparam logic [SYNC_QUATS-1:0] SYNC_SIGNS = 9'b110001011;

    // Code for framing quat k; inv selects the superframe marker
    function automatic logic [1:0] sync_code(input logic [3:0] k, input logic inv);
        logic [3:0] bitpos;
        bitpos = 4'(SYNC_QUATS - 1) - k;
        return {SYNC_SIGNS[bitpos] ^ inv, 1'b0};
    endfunction

endpackage

// File: rtl/dsl_fa_seq.sv
module dsl_fa_seq
    import dsl_fa_pkg::*;
#(
    parameter int GROUPS      = 12,
    parameter int GRP_QUATS   = 9,
    parameter int MAINT_QUATS = 3,
    parameter int FRAMES      = 8,
    localparam int FQ = SYNC_QUATS + GROUPS * GRP_QUATS + MAINT_QUATS,
    localparam int QW = $clog2(FQ),
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output phase_t        phase,
    output logic [QW-1:0] pos,
    output logic [FW-1:0] frm,
    output logic          grp_first,
    output logic          mnt_first
);

    localparam logic [QW-1:0] SYNC_LAST = QW'(SYNC_QUATS - 1);
    localparam logic [QW-1:0] DATA_LAST = QW'(SYNC_QUATS + GROUPS * GRP_QUATS - 1);
    localparam logic [QW-1:0] POS_LAST  = QW'(FQ - 1);
    localparam logic [QW-1:0] SUB_LAST  = QW'(GRP_QUATS - 1);
    localparam logic [FW-1:0] FRM_LAST  = FW'(FRAMES - 1);

    phase_t        state, state_nx;
    logic [QW-1:0] sub;

    // Next-state logic: SYNC_TO_DATA, DATA_TO_MAINT, MAINT_TO_SYNC
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_SYNC:  if (pos == SYNC_LAST) state_nx = PH_DATA;
            PH_DATA:  if (pos == DATA_LAST) state_nx = PH_MAINT;
            PH_MAINT: if (pos == POS_LAST)  state_nx = PH_SYNC;
            default:  state_nx = PH_SYNC;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= PH_SYNC;
        else if (adv) state <= state_nx;
    end

    // Position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            frm <= '0;
            sub <= '0;
        end else if (adv) begin
            if (pos == POS_LAST) begin
                pos <= '0;
                frm <= (frm == FRM_LAST) ? '0 : frm + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
            if (state_nx != state)
                sub <= '0;
            else if (state == PH_DATA && sub == SUB_LAST)
                sub <= '0;
            else
                sub <= sub + 1'b1;
        end
    end

    // Outputs derived from state
    always_comb begin
        phase     = state;
        grp_first = 1'b0;
        mnt_first = 1'b0;
        unique case (state)
            PH_SYNC:  ;
            PH_DATA:  grp_first = (sub == '0);
            PH_MAINT: mnt_first = (sub == '0);
            default:  ;
        endcase
    end

    // R6
    grp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_first |-> ((32'(pos) - SYNC_QUATS) % GRP_QUATS) == 0);

    // R9
    mnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_MAINT |-> pos > DATA_LAST);

    // R4
    sync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_SYNC |-> pos <= SYNC_LAST);

endmodule

// File: rtl/dsl_fa_shift.sv
module dsl_fa_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic [1:0]   head
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n)      sr <= '0;
        else if (load)   sr <= load_val;
        else if (shift)  sr <= {sr[W-3:0], 2'b00};
    end

    assign head = sr[W-1:W-2];

endmodule

// File: rtl/dsl_frame_asm.sv
module dsl_frame_asm
    import dsl_fa_pkg::*;
#(
    parameter int B_BITS      = 8,
    parameter int D_SYS_BITS  = 8,
    parameter int D_USED      = 2,
    parameter int GROUPS      = 12,
    parameter int MAINT_QUATS = 3,
    parameter int FRAMES      = 8,
    localparam int GRP_BITS  = 2 * B_BITS + D_USED,
    localparam int GRP_QUATS = GRP_BITS / 2,
    localparam int MNT_BITS  = 2 * MAINT_QUATS,
    localparam int FQ = SYNC_QUATS + GROUPS * GRP_QUATS + MAINT_QUATS,
    localparam int QW = $clog2(FQ),
    localparam int FW = $clog2(FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  quat_en,
    input  logic [B_BITS-1:0]     b1_in,
    input  logic [B_BITS-1:0]     b2_in,
    input  logic [D_SYS_BITS-1:0] d_in,
    input  logic [MNT_BITS-1:0]   m_in,
    output logic                  grp_take,
    output logic                  mnt_take,
    output logic                  quat_vld,
    output logic [1:0]            quat_out,
    output logic                  sync_flag,
    output logic [QW-1:0]         quat_idx,
    output logic [FW-1:0]         frame_idx
);

    localparam int SH_W = GRP_BITS - 2;
    localparam int M_PAD = SH_W - (MNT_BITS - 2);
    localparam logic [QW-1:0] POS_LAST = QW'(FQ - 1);
    localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES - 1);

    phase_t              phase;
    logic [QW-1:0]       pos;
    logic [FW-1:0]       frm;
    logic                grp_first, mnt_first;
    logic [GRP_BITS-1:0] grp_word;
    logic [SH_W-1:0]     sh_val;
    logic [1:0]          sh_head;
    logic                sh_load, sh_shift;
    logic [1:0]          cur_code;
    logic                cur_sync;

    dsl_fa_seq #(
        .GROUPS     (GROUPS),
        .GRP_QUATS  (GRP_QUATS),
        .MAINT_QUATS(MAINT_QUATS),
        .FRAMES     (FRAMES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (quat_en),
        .phase    (phase),
        .pos      (pos),
        .frm      (frm),
        .grp_first(grp_first),
        .mnt_first(mnt_first)
    );

    // Only the leading D bits travel; the rest of the system byte is dropped
    assign grp_word = {b1_in, b2_in, d_in[D_SYS_BITS-1 -: D_USED]};

    assign sh_load  = quat_en & (grp_first | mnt_first);
    assign sh_shift = quat_en & ~sh_load;
    assign sh_val   = grp_first ? grp_word[SH_W-1:0]
                                : {m_in[MNT_BITS-3:0], {M_PAD{1'b0}}};

    dsl_fa_shift #(.W(SH_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .shift   (sh_shift),
        .load_val(sh_val),
        .head    (sh_head)
    );

    assign grp_take = quat_en & grp_first;
    assign mnt_take = quat_en & mnt_first;

    // Quat selection per phase
    always_comb begin
        cur_code = 2'b00;
        cur_sync = 1'b0;
        unique case (phase)
            PH_SYNC: begin
                cur_code = sync_code(4'(pos), frm == '0);
                cur_sync = 1'b1;
            end
            PH_DATA:  cur_code = grp_first ? grp_word[GRP_BITS-1 -: 2] : sh_head;
            PH_MAINT: cur_code = mnt_first ? m_in[MNT_BITS-1 -: 2] : sh_head;
            default:  ;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quat_vld  <= 1'b0;
            quat_out  <= 2'b00;
            sync_flag <= 1'b0;
            quat_idx  <= '0;
            frame_idx <= '0;
        end else begin
            quat_vld <= quat_en;
            if (quat_en) begin
                quat_out  <= cur_code;
                sync_flag <= cur_sync;
                quat_idx  <= pos;
                frame_idx <= frm;
            end
        end
    end

    // R10
    flag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quat_vld |-> sync_flag == (32'(quat_idx) < SYNC_QUATS));

    // R4
    sync_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quat_vld && sync_flag |-> quat_out[0] == 1'b0);

    // R5
    inv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quat_vld && quat_idx == '0 && frame_idx == '0 |-> quat_out == 2'b00);

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quat_en && quat_vld |=>
            quat_idx == (($past(quat_idx) == POS_LAST) ? '0 : $past(quat_idx) + 1'b1));

    // R3
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quat_en && quat_vld && quat_idx == POS_LAST |=>
            frame_idx == (($past(frame_idx) == FRM_LAST) ? '0 : $past(frame_idx) + 1'b1));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quat_en |=> !quat_vld && $stable(quat_out) && $stable(quat_idx) && $stable(frame_idx));

    // R7
    take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grp_take && mnt_take));

endmodule

// File: tb/dsl_frame_asm_test.sv
module dsl_frame_asm_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       quat_en = 1'b0;
    logic [7:0] b1_in = '0, b2_in = '0, d_in = '0;
    logic [5:0] m_in = '0;
    logic       grp_take, mnt_take, quat_vld, sync_flag;
    logic [1:0] quat_out;
    logic [6:0] quat_idx;
    logic [2:0] frame_idx;

    always #2.5 clk = ~clk;

    dsl_frame_asm uut (
        .clk(clk), .rst_n(rst_n), .quat_en(quat_en),
        .b1_in(b1_in), .b2_in(b2_in), .d_in(d_in), .m_in(m_in),
        .grp_take(grp_take), .mnt_take(mnt_take), .quat_vld(quat_vld),
        .quat_out(quat_out), .sync_flag(sync_flag),
        .quat_idx(quat_idx), .frame_idx(frame_idx)
    );

    int checks = 0;
    int errors = 0;
    bit run = 1'b0;

    // expected item: {flag, code[1:0], idx[6:0], frame[2:0]}
    logic [12:0] exp_q[$];

    localparam logic [8:0] SIGNS = 9'b110001011;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor / scoreboard
    logic [1:0] prev_code = '0;
    logic [6:0] prev_idx = '0;
    logic [2:0] prev_frm = '0;
    always @(negedge clk) begin
        if (run) begin
            if (quat_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected quat", 1, 0);
                end else begin
                    logic [12:0] e;
                    string ctag;
                    e = exp_q.pop_front();
                    if (e[9:3] < 9)        ctag = (e[2:0] == 0) ? "R5 code" : "R4 code";
                    else if (e[9:3] < 117) ctag = "R6 code";
                    else                   ctag = "R9 code";
                    chk(quat_out == e[11:10], ctag, quat_out, e[11:10]);
                    chk(sync_flag == e[12], "R10 flag", sync_flag, e[12]);
                    chk(quat_idx == e[9:3], "R2 idx", quat_idx, e[9:3]);
                    chk(frame_idx == e[2:0], "R3 frame", frame_idx, e[2:0]);
                end
            end else begin
                chk(quat_out == prev_code && quat_idx == prev_idx && frame_idx == prev_frm,
                    "R11 hold", {quat_out, quat_idx, frame_idx}, {prev_code, prev_idx, prev_frm});
            end
            prev_code = quat_out;
            prev_idx  = quat_idx;
            prev_frm  = frame_idx;
        end
    end

    // Driver
    initial begin
        int q = 0;
        int f = 0;
        logic [17:0] gw = '0;
        logic [5:0]  mw = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(quat_vld == 0 && quat_out == 0 && sync_flag == 0, "R1 outputs", {quat_vld, quat_out, sync_flag}, 0);
        chk(quat_idx == 0 && frame_idx == 0, "R1 counters", {quat_idx, frame_idx}, 0);
        chk(grp_take == 0 && mnt_take == 0, "R1 takes", {grp_take, mnt_take}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(quat_vld == 0 && quat_idx == 0, "R1 idle after reset", {quat_vld, quat_idx}, 0);
        run = 1'b1;
        for (int step = 0; step < 1280; step++) begin
            bit en, et, em;
            logic [1:0] code;
            logic flag;
            @(negedge clk);
            en = (step % 7) != 6;
            et = 1'b0;
            em = 1'b0;
            quat_en = en;
            b1_in = 8'($urandom);
            b2_in = 8'($urandom);
            d_in  = 8'($urandom);
            m_in  = 6'($urandom);
            if (en) begin
                flag = 1'b0;
                if (q < 9) begin
                    code = {SIGNS[8 - q] ^ (f == 0), 1'b0};
                    flag = 1'b1;
                end else if (q < 117) begin
                    int k;
                    k = (q - 9) % 9;
                    if (k == 0) begin
                        gw = 18'($urandom);
                        b1_in = gw[17:10];
                        b2_in = gw[9:2];
                        d_in  = {gw[1:0], 6'($urandom)}; // R8 low bits random
                        et = 1'b1;
                    end
                    code = gw[17 - 2*k -: 2];
                end else begin
                    int k;
                    k = q - 117;
                    if (k == 0) begin
                        mw = 6'($urandom);
                        m_in = mw;
                        em = 1'b1;
                    end
                    code = mw[5 - 2*k -: 2];
                end
                exp_q.push_back({flag, code, 7'(q), 3'(f)});
                q++;
                if (q == 120) begin
                    q = 0;
                    f = (f + 1) % 8;
                end
            end
            #1;
            chk(grp_take == et, "R7 grp_take", grp_take, et);
            chk(mnt_take == em, "R9 mnt_take", mnt_take, em);
        end
        @(negedge clk);
        quat_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all quats emitted", exp_q.size(), 0);
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule